// File: doc/BRIEF.md
# Serial Port Register Bank

This block is the register file and event logic of a simple serial port. A host reaches it through a word-indexed read/write bus. It exposes four control words, two status words, a read-only test word, and storage for baud-count, modulator, FIFO-control and one-millisecond settings. The line-side serializer is not part of this block. Received characters arrive as a byte with a valid strobe, together with a separate break-event input. Characters to send leave as a byte with a one-cycle valid strobe. One level interrupt combines the ready and empty conditions with their enables.

Two small state machines carry the dynamic behaviour:

- **Receive holding machine.** States `RX_EMPTY` and `RX_FULL`.
  - `RX_EMPTY -> RX_FULL` on an accepted byte or on a break event.
  - `RX_FULL -> RX_FULL` on a break event, which overwrites the buffer.
  - `RX_FULL -> RX_EMPTY` when the host reads the receive-data word.
- **Transmit machine.** States `TX_IDLE` and `TX_SEND`.
  - `TX_IDLE -> TX_SEND` on an enabled transmit-data write.
  - `TX_SEND -> TX_SEND` on a further enabled write.
  - `TX_SEND -> TX_IDLE` after one cycle with no new write.
- **Soft reset.** A soft reset forces both machines back to `RX_EMPTY` and `TX_IDLE`.

The bus index is the byte address shifted right by two. The index map is:

| Index | Word |
|---|---|
| 0x00 | receive data |
| 0x10 | transmit data |
| 0x20 | control 1 |
| 0x21 | control 2 |
| 0x22 | control 3 |
| 0x23 | control 4 |
| 0x24 | FIFO control |
| 0x25 | status 1 |
| 0x26 | status 2 |
| 0x29 | baud-count write port |
| 0x2A | modulator |
| 0x2B | baud count |
| 0x2C | one-millisecond |
| 0x2D | test |

Top module: `sio_regbank`

## Requirements
- R1: After hardware reset, reads return the following values, `bus_rdata` is 0 and `irq` is 0.

  | Word | Reset value |
  |---|---|
  | status 1 | 0x6040 (tx-ready bit 13, rts bit 14, rx-idle bit 6) |
  | status 2 | 0x4028 (tx-empty bit 14, carrier bit 5, tx-complete bit 3) |
  | test | 0x0060 (tx-empty bit 6, rx-empty bit 5) |
  | control 1 | 0 |
  | control 2 | 0x0001 |
  | control 3 | 0x0700 |
  | modulator | 0 |
  | baud count | 4 |
  | receive data | 0x4000 (error bit 14) |

- R2: Read timing and decode.
  - Read data appears on `bus_rdata` the cycle after `bus_rd`, with bits 31:16 zero.
  - A read of an index not in the map returns 0.
  - A read of the transmit-data index also returns 0.
- R3: Plain storage words.
  - Writes keep only the low 16 bits.
  - A write to index 0x29 updates the baud count (read at 0x2B), while a read of 0x29 returns 0.
  - Writes to the test word are ignored.
  - Control 3, control 4, FIFO control, modulator and one-millisecond read back what was written.
- R4: Control-2 writes and soft reset.
  - A control-2 write with bit 0 clear performs a soft reset. The soft reset restores control 1, control 3, the modulator, the baud count, both status words and the receive buffer to their R1 values, and empties the receive buffer.
  - After that write, control 2 reads back the written value with bit 0 set.
  - Control 4, FIFO control and one-millisecond keep their values across a soft reset.
  - A control-2 write with bit 0 set does not reset.
- R5: A byte arriving while the buffer is empty is stored in bits 7:0 of the receive buffer. It sets status-1 bit 9 and status-2 bit 0, and clears test bit 5.
- R6: A byte arriving while the buffer is full is ignored.
- R7: Reading receive data.
  - A read of receive data while full returns the buffer with bit 15 set, and empties the buffer. Emptying clears status-1 bit 9 and status-2 bit 0 and sets test bit 5.
  - A read while empty returns the buffer without bit 15 and changes nothing.
- R8: A break event loads the buffer with 0x5800 (break bit 11, framing bit 12, error bit 14), marks it full and sets status-2 bit 2. It does so even when the buffer is already full.
- R9: Transmitting.
  - With control-2 bit 2 set, a write to transmit data drives `line_tx_valid` high for one cycle with the low byte on `line_tx_byte`.
  - During that cycle status-1 bit 13 and status-2 bit 3 read 0, and they return to 1 afterwards.
  - With control-2 bit 2 clear, the write sends nothing.
- R10: Writing 1s to status 1 clears only bits within mask 0x9DB0. Writing 1s to status 2 clears only bits within mask 0x9DD6. All other bits are unaffected.
- R11: `irq` is high when status-1 bits 13 or 9 are set together with the same bit of control 1.
- R12: `irq` is also high when status 2 shares a set bit with a mask. The mask holds bit 14 when control-1 bit 6 is set, plus control-4 bits 3 and 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address; index is bits ADDR_W-1:2 |
| bus_wdata | input | BUS_W | Write data |
| bus_rdata | output | BUS_W | Read data, valid the cycle after `bus_rd` |
| line_tx_valid | output | 1 | Transmit byte strobe |
| line_tx_byte | output | BYTE_W | Transmit byte |
| line_rx_valid | input | 1 | Received byte strobe |
| line_rx_byte | input | BYTE_W | Received byte |
| line_brk | input | 1 | Break event |
| irq | output | 1 | Combined level interrupt |

## Verification
A receive machine stuck in the wrong state shows up at the port within a cycle. It appears as a wrong status-1 bit 9, status-2 bit 0 or test bit 5 on the next read, as a missing or spurious bit 15 on a receive-data read, and as an `irq` change once the ready enables are set. A transmit machine that fails to return to idle leaves `line_tx_valid` high and the ready bits low one cycle too long, and that is visible on a read issued right after the write. A soft reset that misses a register, or clears one it should keep, shows up on the next read of that register.

// File: rtl/sio_pkg.sv
package sio_pkg;

    localparam int unsigned REG_W = 16;

    // word indices (byte address >> 2)
    localparam int unsigned IX_RXD   = 'h00;
    localparam int unsigned IX_TXD   = 'h10;
    localparam int unsigned IX_CTL1  = 'h20;
    localparam int unsigned IX_CTL2  = 'h21;
    localparam int unsigned IX_CTL3  = 'h22;
    localparam int unsigned IX_CTL4  = 'h23;
    localparam int unsigned IX_FIFO  = 'h24;
    localparam int unsigned IX_STS1  = 'h25;
    localparam int unsigned IX_STS2  = 'h26;
    localparam int unsigned IX_BINC  = 'h29;
    localparam int unsigned IX_MOD   = 'h2A;
    localparam int unsigned IX_BCNT  = 'h2B;
    localparam int unsigned IX_MSEC  = 'h2C;
    localparam int unsigned IX_TEST  = 'h2D;

    // bit positions
    localparam int unsigned B_RX_CHRDY = 15;
    localparam int unsigned B_RX_ERR   = 14;
    localparam int unsigned B_RX_FRM   = 12;
    localparam int unsigned B_RX_BRK   = 11;
    localparam int unsigned B_S1_TRDY  = 13;
    localparam int unsigned B_S1_RRDY  = 9;
    localparam int unsigned B_S2_TXE   = 14;
    localparam int unsigned B_S2_TXDONE = 3;
    localparam int unsigned B_S2_BRKDET = 2;
    localparam int unsigned B_S2_RDR   = 0;
    localparam int unsigned B_C1_TXEEN = 6;
    localparam int unsigned B_C2_SRST  = 0;
    localparam int unsigned B_C2_TXEN  = 2;
    localparam int unsigned B_TS_RXE   = 5;

    // reset values and masks
    localparam logic [REG_W-1:0] S1_RST    = 16'h6040;
    localparam logic [REG_W-1:0] S2_RST    = 16'h4028;
    localparam logic [REG_W-1:0] TEST_RST  = 16'h0060;
    localparam logic [REG_W-1:0] C2_RST    = 16'h0001;
    localparam logic [REG_W-1:0] C3_RST    = 16'h0700;
    localparam logic [REG_W-1:0] BCNT_RST  = 16'h0004;
    localparam logic [REG_W-1:0] RXBUF_RST = 16'h4000;
    localparam logic [REG_W-1:0] BRK_WORD  = 16'h5800;
    localparam logic [REG_W-1:0] S1_W1C    = 16'h9DB0;
    localparam logic [REG_W-1:0] S2_W1C    = 16'h9DD6;
    localparam logic [REG_W-1:0] IRQ1_SEL  = 16'h2200;
    localparam logic [REG_W-1:0] IRQ2_C4   = 16'h0009;

    typedef enum logic {RX_EMPTY, RX_FULL} rx_state_e;
    typedef enum logic {TX_IDLE, TX_SEND} tx_state_e;

endpackage

// File: rtl/sio_rx_hold.sv
module sio_rx_hold
    import sio_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              brk_evt,
    input  logic              take,
    output logic              full,
    output logic [REG_W-1:0]  hold,
    output logic              brk_load
);

    rx_state_e          state_q, state_d;
    logic [REG_W-1:0]   hold_q, hold_d;
    logic               load_now;

    always_comb begin
        state_d  = state_q;
        hold_d   = hold_q;
        load_now = 1'b0;
        unique case (state_q)
            RX_EMPTY: begin
                if (brk_evt) begin
                    state_d  = RX_FULL;
                    hold_d   = BRK_WORD;
                    load_now = 1'b1;
                end else if (rx_valid) begin
                    state_d  = RX_FULL;
                    hold_d   = {{(REG_W-BYTE_W){1'b0}}, rx_byte};
                    load_now = 1'b1;
                end
            end
            RX_FULL: begin
                if (brk_evt) begin
                    hold_d   = BRK_WORD;
                    load_now = 1'b1;
                end else if (take) begin
                    state_d  = RX_EMPTY;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RX_EMPTY;
            hold_q  <= RXBUF_RST;
        end else if (soft_rst) begin
            state_q <= RX_EMPTY;
            hold_q  <= RXBUF_RST;
        end else begin
            state_q <= state_d;
            hold_q  <= hold_d;
        end
    end

    always_comb begin
        full     = (state_q == RX_FULL);
        hold     = hold_q;
        brk_load = load_now && hold_d[B_RX_BRK] && !soft_rst;
    end

    // R5
    rx_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!full && rx_valid && !brk_evt && !soft_rst)
        |=> (full && hold[BYTE_W-1:0] == $past(rx_byte)));

    // R6
    rx_full_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && rx_valid && !brk_evt && !take && !soft_rst)
        |=> (full && $stable(hold)));

    // R8
    rx_break_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_evt && !soft_rst) |=> (full && hold == BRK_WORD));

    // R7
    rx_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && take && !brk_evt) |=> !full);

endmodule

// File: rtl/sio_tx_path.sv
module sio_tx_path
    import sio_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              send,
    input  logic [BYTE_W-1:0] wbyte,
    output logic              line_valid,
    output logic [BYTE_W-1:0] line_byte,
    output logic              busy
);

    tx_state_e          state_q, state_d;
    logic [BYTE_W-1:0]  byte_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE: if (send) state_d = TX_SEND;
            TX_SEND: if (!send) state_d = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TX_IDLE;
            byte_q  <= '0;
        end else if (soft_rst) begin
            state_q <= TX_IDLE;
        end else begin
            state_q <= state_d;
            if (send) byte_q <= wbyte;
        end
    end

    always_comb begin
        line_valid = (state_q == TX_SEND);
        busy       = (state_q == TX_SEND);
        line_byte  = byte_q;
    end

    // R9
    tx_emit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (send && !soft_rst) |=> (line_valid && line_byte == $past(wbyte)));

    // R9
    tx_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (line_valid && !send) |=> !line_valid);

endmodule

// File: rtl/sio_irq_comb.sv
module sio_irq_comb
    import sio_pkg::*;
(
    input  logic [REG_W-1:0] sts1,
    input  logic [REG_W-1:0] sts2,
    input  logic [REG_W-1:0] ctl1,
    input  logic [REG_W-1:0] ctl4,
    output logic             irq
);

    logic [REG_W-1:0] term1, mask2, term2;

    always_comb begin
        term1 = sts1 & ctl1 & IRQ1_SEL;
        mask2 = ctl4 & IRQ2_C4;
        if (ctl1[B_C1_TXEEN]) mask2[B_S2_TXE] = 1'b1;
        term2 = sts2 & mask2;
        irq   = (|term1) || (|term2);
    end

endmodule

// File: rtl/sio_regbank.sv
module sio_regbank
    import sio_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int BUS_W  = 32,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              line_tx_valid,
    output logic [BYTE_W-1:0] line_tx_byte,
    input  logic              line_rx_valid,
    input  logic [BYTE_W-1:0] line_rx_byte,
    input  logic              line_brk,
    output logic              irq
);

    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] idx;
    logic [REG_W-1:0] wlo;
    logic             unused_bits;

    assign idx         = bus_addr[ADDR_W-1:2];
    assign wlo         = bus_wdata[REG_W-1:0];
    assign unused_bits = ^{bus_addr[1:0], bus_wdata[BUS_W-1:REG_W]};

    function automatic logic at(input logic [IDX_W-1:0] a, input int unsigned ix);
        return a == IDX_W'(ix);
    endfunction

    logic [REG_W-1:0] ctl1_q, ctl2_q, ctl3_q, ctl4_q;
    logic [REG_W-1:0] fifo_q, msec_q, mod_q, bcnt_q;
    logic [REG_W-1:0] sts1_q, sts2_q;
    logic [REG_W-1:0] sts1_v, sts2_v, test_v, rxd_v, rd_mux;
    logic [BUS_W-1:0] rdata_q;

    logic soft_rst, rx_take, tx_send;
    logic rx_full, tx_busy, brk_load;
    logic [REG_W-1:0] rx_hold;

    assign soft_rst = bus_wr && at(idx, IX_CTL2) && !bus_wdata[B_C2_SRST];
    assign rx_take  = bus_rd && at(idx, IX_RXD);
    assign tx_send  = bus_wr && at(idx, IX_TXD) && ctl2_q[B_C2_TXEN];

    sio_rx_hold #(.BYTE_W(BYTE_W)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .rx_valid (line_rx_valid),
        .rx_byte  (line_rx_byte),
        .brk_evt  (line_brk),
        .take     (rx_take),
        .full     (rx_full),
        .hold     (rx_hold),
        .brk_load (brk_load)
    );

    sio_tx_path #(.BYTE_W(BYTE_W)) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_rst   (soft_rst),
        .send       (tx_send),
        .wbyte      (bus_wdata[BYTE_W-1:0]),
        .line_valid (line_tx_valid),
        .line_byte  (line_tx_byte),
        .busy       (tx_busy)
    );

    // live status views: dynamic bits come from the two machines
    always_comb begin
        sts1_v                = sts1_q;
        sts1_v[B_S1_TRDY]     = !tx_busy;
        sts1_v[B_S1_RRDY]     = rx_full;
        sts2_v                = sts2_q;
        sts2_v[B_S2_TXDONE]   = !tx_busy;
        sts2_v[B_S2_RDR]      = rx_full;
        test_v                = TEST_RST;
        test_v[B_TS_RXE]      = !rx_full;
        rxd_v                 = rx_hold;
        rxd_v[B_RX_CHRDY]     = rx_hold[B_RX_CHRDY] | rx_full;
    end

    sio_irq_comb u_irq (
        .sts1 (sts1_v),
        .sts2 (sts2_v),
        .ctl1 (ctl1_q),
        .ctl4 (ctl4_q),
        .irq  (irq)
    );

    // register writes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl1_q <= '0;
            ctl2_q <= C2_RST;
            ctl3_q <= C3_RST;
            ctl4_q <= '0;
            fifo_q <= '0;
            msec_q <= '0;
            mod_q  <= '0;
            bcnt_q <= BCNT_RST;
            sts1_q <= S1_RST;
            sts2_q <= S2_RST;
        end else if (soft_rst) begin
            ctl1_q <= '0;
            ctl2_q <= wlo | C2_RST;
            ctl3_q <= C3_RST;
            mod_q  <= '0;
            bcnt_q <= BCNT_RST;
            sts1_q <= S1_RST;
            sts2_q <= S2_RST;
        end else begin
            if (bus_wr && at(idx, IX_CTL1)) ctl1_q <= wlo;
            if (bus_wr && at(idx, IX_CTL2)) ctl2_q <= wlo;
            if (bus_wr && at(idx, IX_CTL3)) ctl3_q <= wlo;
            if (bus_wr && at(idx, IX_CTL4)) ctl4_q <= wlo;
            if (bus_wr && at(idx, IX_FIFO)) fifo_q <= wlo;
            if (bus_wr && at(idx, IX_MSEC)) msec_q <= wlo;
            if (bus_wr && at(idx, IX_MOD))  mod_q  <= wlo;
            if (bus_wr && at(idx, IX_BINC)) bcnt_q <= wlo;
            if (bus_wr && at(idx, IX_STS1)) sts1_q <= sts1_q & ~(wlo & S1_W1C);
            sts2_q <= ((bus_wr && at(idx, IX_STS2)) ? (sts2_q & ~(wlo & S2_W1C)) : sts2_q)
                      | (brk_load ? (REG_W'(1) << B_S2_BRKDET) : '0);
        end
    end

    // read mux and one-cycle read register
    always_comb begin
        rd_mux = '0;
        case (idx)
            IDX_W'(IX_RXD):  rd_mux = rxd_v;
            IDX_W'(IX_CTL1): rd_mux = ctl1_q;
            IDX_W'(IX_CTL2): rd_mux = ctl2_q;
            IDX_W'(IX_CTL3): rd_mux = ctl3_q;
            IDX_W'(IX_CTL4): rd_mux = ctl4_q;
            IDX_W'(IX_FIFO): rd_mux = fifo_q;
            IDX_W'(IX_STS1): rd_mux = sts1_v;
            IDX_W'(IX_STS2): rd_mux = sts2_v;
            IDX_W'(IX_MOD):  rd_mux = mod_q;
            IDX_W'(IX_BCNT): rd_mux = bcnt_q;
            IDX_W'(IX_MSEC): rd_mux = msec_q;
            IDX_W'(IX_TEST): rd_mux = test_v;
            default:         rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rdata_q <= '0;
        else if (bus_rd) rdata_q <= {{(BUS_W-REG_W){1'b0}}, rd_mux};
    end

    assign bus_rdata = rdata_q;

    // R4
    ctl2_srst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && at(idx, IX_CTL2)) |=> ctl2_q[B_C2_SRST]);

    // R4
    soft_rst_sts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (sts1_q == S1_RST && !rx_full && ctl1_q == '0));

    // R3
    bcnt_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && at(idx, IX_BINC)) |=> (bcnt_q == $past(wlo)));

    // R11
    irq_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sts1_v[B_S1_TRDY] && ctl1_q[B_S1_TRDY]) |-> irq);

    // R12
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl1_q == '0 && ctl4_q == '0) |-> !irq);

    // R10
    sts1_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && at(idx, IX_STS1) && !soft_rst)
        |=> ((sts1_q & ~S1_W1C) == ($past(sts1_q) & ~S1_W1C)));

endmodule

// File: tb/sio_regbank_bench.sv
module sio_regbank_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WDOG_CYC   = 20000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_wr, bus_rd;
    logic [11:0] bus_addr;
    logic [31:0] bus_wdata, bus_rdata;
    logic        line_tx_valid;
    logic [7:0]  line_tx_byte;
    logic        line_rx_valid;
    logic [7:0]  line_rx_byte;
    logic        line_brk;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sio_regbank u_sio_regbank (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .line_tx_valid(line_tx_valid), .line_tx_byte(line_tx_byte),
        .line_rx_valid(line_rx_valid), .line_rx_byte(line_rx_byte),
        .line_brk(line_brk), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // all tasks start and end at a falling edge
    task automatic wr(input int ix, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = 12'(ix << 2); bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_chk(input string req, input int ix, input logic [31:0] exp);
        bus_rd = 1'b1; bus_addr = 12'(ix << 2);
        @(negedge clk);
        bus_rd = 1'b0;
        chk(req, bus_rdata, exp);
    endtask

    task automatic push(input logic [7:0] b);
        line_rx_valid = 1'b1; line_rx_byte = b;
        @(negedge clk);
        line_rx_valid = 1'b0;
    endtask

    task automatic brk();
        line_brk = 1'b1;
        @(negedge clk);
        line_brk = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 irq", 32'(irq), 0);
        chk("R1 rdata", bus_rdata, 0);
        chk("R1 tx_valid", 32'(line_tx_valid), 0);
        rd_chk("R1 sts1", 'h25, 32'h6040);
        rd_chk("R1 sts2", 'h26, 32'h4028);
        rd_chk("R1 test", 'h2D, 32'h0060);
        rd_chk("R1 ctl1", 'h20, 32'h0);
        rd_chk("R1 ctl2", 'h21, 32'h0001);
        rd_chk("R1 ctl3", 'h22, 32'h0700);
        rd_chk("R1 mod", 'h2A, 32'h0);
        rd_chk("R1 bcnt", 'h2B, 32'h0004);
        rd_chk("R1 rxd", 'h00, 32'h4000);
    endtask

    task automatic t_decode();
        rd_chk("R2 unmapped", 'h05, 32'h0);
        rd_chk("R2 txd read", 'h10, 32'h0);
        wr('h29, 32'h1234_0077);
        rd_chk("R3 bcnt via 0x29", 'h2B, 32'h0077);
        rd_chk("R3 0x29 reads 0", 'h29, 32'h0);
        wr('h22, 32'hABCD_1234);
        rd_chk("R3 ctl3 low16", 'h22, 32'h1234);
        wr('h2D, 32'h0000_FFFF);
        rd_chk("R3 test ignored", 'h2D, 32'h0060);
        wr('h24, 32'h0000_0A81);
        rd_chk("R3 fifo", 'h24, 32'h0A81);
        wr('h2C, 32'h0000_00AB);
        rd_chk("R3 msec", 'h2C, 32'h00AB);
        wr('h2A, 32'h0000_0055);
        rd_chk("R3 mod", 'h2A, 32'h0055);
    endtask

    task automatic t_rx();
        push(8'h41);
        rd_chk("R5 sts1 rrdy", 'h25, 32'h6240);
        rd_chk("R5 sts2 rdr", 'h26, 32'h4029);
        rd_chk("R5 test rxe clr", 'h2D, 32'h0040);
        push(8'h42);
        rd_chk("R6 r7 rxd full", 'h00, 32'h8041);
        rd_chk("R7 sts1 after", 'h25, 32'h6040);
        rd_chk("R7 sts2 after", 'h26, 32'h4028);
        rd_chk("R7 test after", 'h2D, 32'h0060);
        rd_chk("R7 rxd empty", 'h00, 32'h0041);
        rd_chk("R7 still empty", 'h25, 32'h6040);
    endtask

    task automatic t_break();
        push(8'h33);
        brk();
        rd_chk("R8 sts2 brk", 'h26, 32'h402D);
        wr('h26, 32'h0000_FFFF);
        rd_chk("R10 sts2 w1c", 'h26, 32'h4029);
        wr('h25, 32'h0000_FFFF);
        rd_chk("R10 sts1 w1c", 'h25, 32'h6240);
        rd_chk("R8 rxd brk word", 'h00, 32'hD800);
        rd_chk("R8 sts2 empty", 'h26, 32'h4028);
    endtask

    task automatic t_tx();
        wr('h10, 32'h0000_01A5);
        chk("R9 no enable", 32'(line_tx_valid), 0);
        wr('h21, 32'h0000_0005);
        wr('h10, 32'h0000_01A5);
        chk("R9 tx valid", 32'(line_tx_valid), 1);
        chk("R9 tx byte", 32'(line_tx_byte), 32'hA5);
        rd_chk("R9 sts2 txdone low", 'h26, 32'h4020);
        chk("R9 valid one cycle", 32'(line_tx_valid), 0);
        wr('h10, 32'h0000_003C);
        chk("R9 tx byte 2", 32'(line_tx_byte), 32'h3C);
        rd_chk("R9 sts1 trdy low", 'h25, 32'h4040);
        rd_chk("R9 sts1 restored", 'h25, 32'h6040);
    endtask

    task automatic t_irq();
        wr('h20, 32'h0000_2000);
        chk("R11 trdy irq", 32'(irq), 1);
        wr('h10, 32'h0000_0011);
        chk("R11 irq drops while sending", 32'(irq), 0);
        @(negedge clk);
        chk("R11 irq back", 32'(irq), 1);
        wr('h20, 32'h0000_0200);
        chk("R11 rrdy idle", 32'(irq), 0);
        push(8'h10);
        chk("R11 rrdy irq", 32'(irq), 1);
        rd_chk("R11 rxd", 'h00, 32'h8010);
        chk("R11 rrdy cleared", 32'(irq), 0);
        wr('h20, 32'h0);
        wr('h23, 32'h0000_0008);
        chk("R12 txdone en", 32'(irq), 1);
        wr('h23, 32'h0000_0001);
        chk("R12 rdr idle", 32'(irq), 0);
        push(8'h20);
        chk("R12 rdr irq", 32'(irq), 1);
        rd_chk("R12 rxd", 'h00, 32'h8020);
        chk("R12 rdr cleared", 32'(irq), 0);
        wr('h23, 32'h0);
        wr('h20, 32'h0000_0040);
        chk("R12 txe en", 32'(irq), 1);
        wr('h20, 32'h0);
        chk("R12 all off", 32'(irq), 0);
    endtask

    task automatic t_srst();
        wr('h20, 32'h0000_2241);
        wr('h22, 32'h0000_1234);
        wr('h23, 32'h0000_0009);
        wr('h2C, 32'h0000_00AB);
        wr('h2A, 32'h0000_0055);
        wr('h29, 32'h0000_0077);
        wr('h24, 32'h0000_0A81);
        push(8'h5A);
        wr('h21, 32'h0000_0006);
        rd_chk("R4 ctl2 srst forced", 'h21, 32'h0007);
        rd_chk("R4 ctl1", 'h20, 32'h0);
        rd_chk("R4 ctl3", 'h22, 32'h0700);
        rd_chk("R4 mod", 'h2A, 32'h0);
        rd_chk("R4 bcnt", 'h2B, 32'h0004);
        rd_chk("R4 sts1", 'h25, 32'h6040);
        rd_chk("R4 sts2", 'h26, 32'h4028);
        rd_chk("R4 rxd", 'h00, 32'h4000);
        rd_chk("R4 ctl4 kept", 'h23, 32'h0009);
        rd_chk("R4 msec kept", 'h2C, 32'h00AB);
        rd_chk("R4 fifo kept", 'h24, 32'h0A81);
        wr('h20, 32'h0000_0001);
        wr('h21, 32'h0000_0003);
        rd_chk("R4 ctl2 no reset", 'h21, 32'h0003);
        rd_chk("R4 ctl1 kept", 'h20, 32'h0001);
    endtask

    initial begin
        rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
        line_rx_valid = 1'b0; line_rx_byte = '0; line_brk = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_decode();
        t_rx();
        t_break();
        t_tx();
        t_irq();
        t_srst();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (WDOG_CYC) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule